// File: doc/BRIEF.md
# Trimmed-Mean Clock Offset Corrector

This block produces one node's clock correction for a distributed network of clocks. After a synchronization round, the node offers the block one vector of signed time differences. Each difference is a remote node's reported time minus the local time. A per-slot mask marks the slots whose frame arrived. The block always adds the node's own zero difference to the valid readings. It sorts the valid readings in ascending order and drops the `K_FAULTS` lowest and the `K_FAULTS` highest. It then returns the truncated mean of the readings that remain. Because the outermost readings are removed, up to `K_FAULTS` arbitrarily faulty nodes cannot pull the result outside the range of the honest readings.

The input side is a valid/ready stream that carries one whole vector per transfer. The block takes only one vector at a time. `in_ready` is high only while the block is idle, so a sender holding `in_valid` simply waits. The result side is also valid/ready. The result stays on the outputs, unchanged, until the consumer raises `out_ready`. The block accepts no new vector before that handshake has happened.

Every transfer takes the same number of cycles, whatever the data and whatever the mask. This fixed timing lets the node plan when the correction becomes available. When too few readings are valid for the fault bound, the block gives no correction and raises a fail flag instead.

Top module: `ftac_corrector`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A vector is taken on a cycle with `in_valid` and `in_ready` both high. While a vector is being processed or its result is waiting, `in_ready` stays low, and changes on `in_valid`, `in_diff` and `in_mask` do not affect the pending result.
- R2: Slot i carries a two's-complement difference in `in_diff[i*DW +: DW]`. The slot is counted only when `in_mask[i]` is 1, and masked slots have no effect on the result. A local reading of value 0 is always counted, so the valid count is the popcount of the mask plus one.
- R3: The valid readings are arranged in ascending signed order before any reading is dropped.
- R4: Exactly `K_FAULTS` readings are dropped from the low end of the ordered set and `K_FAULTS` from the high end. This holds for duplicates and outliers of any size.
- R5: `out_corr` is the sum of the kept readings divided by their count, which is the valid count minus 2·`K_FAULTS`. The quotient is truncated toward zero.
- R6: If the valid count is below 3·`K_FAULTS`+1, then `out_fail` is 1 and `out_corr` is 0. At exactly 3·`K_FAULTS`+1 valid readings a normal correction is produced and `out_fail` is 0.
- R7: `out_valid` rises exactly 2·(`N_NODES`+1) + (`DW` + clog2(`N_NODES`+2)) + 2 cycles after the accepting clock edge, whatever the data and the mask. With the default parameters this is 35 cycles.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_corr` and `out_fail` hold steady. After the edge on which both are high, `out_valid` is 0 and `in_ready` is 1.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, `out_corr` is 0 and `out_fail` is 0.
- R10: Readings at the ends of the `DW`-bit range (all maximum, all minimum) give the exact extreme mean, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Difference vector offered |
| in_ready | output | 1 | Block idle, vector can be taken |
| in_diff | input | N_NODES*DW | Signed differences, slot i at bits i*DW upward |
| in_mask | input | N_NODES | 1 = slot i holds a received reading |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_corr | output | DW | Signed correction (0 when failing) |
| out_fail | output | 1 | Too few valid readings for the fault bound |

## Verification
The main function is tried with several kinds of vectors:
- an evenly spaced ramp, where dropping the wrong reading shifts the mean;
- a single huge outlier, which shows whether the trimming takes the real maximum;
- all-negative readings whose mean is not an integer, which separate truncation toward zero from flooring;
- sparse masks that hold garbage in the masked slots, which expose any masked slot that leaks into the sum or the count;
- valid counts one below and exactly at 3K+1, which pin the fail boundary;
- vectors at the full positive and full negative limits, which expose sum or sign overflow.

A separate stimulus holds back `out_ready` while new vectors are pushed against a busy block. It checks that the held result does not move and that the interfering input is ignored.

// File: rtl/ftac_pkg.sv
package ftac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SORT,
    ST_SUM,
    ST_DIV,
    ST_FIN,
    ST_HOLD
  } ftac_state_e;

endpackage

// File: rtl/ftac_sort_net.sv
// Odd-even transposition sorter: one compare-swap phase per step.
module ftac_sort_net #(
  parameter int M  = 7,
  parameter int KW = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                odd_i,
  input  logic [M-1:0][KW-1:0] keys_i,
  output logic [M-1:0][KW-1:0] keys_o
);

  logic [M-1:0][KW-1:0] keys_q;
  logic [M-1:0][KW-1:0] nxt;

  for (genvar j = 0; j < M; j++) begin : g_cs
    localparam bit LO_PAR = bit'(j % 2);
    localparam bit HI_PAR = bit'((j + 1) % 2);
    if (j == 0) begin : g_first
      logic lo_swap;
      assign lo_swap = (odd_i == LO_PAR) && (keys_q[j] > keys_q[j+1]);
      assign nxt[j]  = lo_swap ? keys_q[j+1] : keys_q[j];
    end else if (j == M - 1) begin : g_last
      logic hi_swap;
      assign hi_swap = (odd_i == HI_PAR) && (keys_q[j-1] > keys_q[j]);
      assign nxt[j]  = hi_swap ? keys_q[j-1] : keys_q[j];
    end else begin : g_mid
      logic lo_swap, hi_swap;
      assign lo_swap = (odd_i == LO_PAR) && (keys_q[j] > keys_q[j+1]);
      assign hi_swap = (odd_i == HI_PAR) && (keys_q[j-1] > keys_q[j]);
      assign nxt[j]  = lo_swap ? keys_q[j+1] : (hi_swap ? keys_q[j-1] : keys_q[j]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       keys_q <= '0;
    else if (load_i)  keys_q <= keys_i;
    else if (step_i)  keys_q <= nxt;
  end

  assign keys_o = keys_q;

endmodule

// File: rtl/ftac_trim_sum.sv
// Accumulates the decoded readings whose position lies in the kept window.
module ftac_trim_sum #(
  parameter int DW = 16,
  parameter int SW = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 take_i,
  input  logic [DW:0]          key_i,
  output logic signed [SW-1:0] sum_o
);

  logic signed [DW-1:0] val;
  logic signed [SW-1:0] val_ext;

  // key layout: {invalid, value with sign bit inverted}
  assign val     = {~key_i[DW-1], key_i[DW-2:0]};
  assign val_ext = {{(SW-DW){val[DW-1]}}, val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sum_o <= '0;
    else if (clear_i) sum_o <= '0;
    else if (take_i)  sum_o <= sum_o + val_ext;
  end

endmodule

// File: rtl/ftac_divider.sv
// Restoring unsigned divider, one quotient bit per step, MSB first.
module ftac_divider #(
  parameter int SW = 19,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [SW-1:0] dvd_i,
  input  logic [CW-1:0] dvs_i,
  output logic [SW-1:0] quo_o
);

  logic [SW-1:0] dvd_q;
  logic [CW-1:0] rem_q;
  logic [CW-1:0] dvs_q;
  logic          busy_q;
  logic [CW:0]   trial;
  logic          fits;

  assign trial = {rem_q, dvd_q[SW-1]};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_o  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      dvd_q  <= dvd_i;
      rem_q  <= '0;
      dvs_q  <= dvs_i;
      quo_o  <= '0;
      busy_q <= 1'b1;
    end else if (step_i) begin
      dvd_q <= {dvd_q[SW-2:0], 1'b0};
      rem_q <= fits ? CW'(trial - {1'b0, dvs_q}) : trial[CW-1:0];
      quo_o <= {quo_o[SW-2:0], fits};
    end
  end

  // R5: partial remainder must stay below the divisor during a division
  p_rem_below_dvs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < dvs_q));

endmodule

// File: rtl/ftac_corrector.sv
module ftac_corrector
  import ftac_pkg::*;
#(
  parameter int N_NODES  = 6,
  parameter int DW       = 16,
  parameter int K_FAULTS = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [N_NODES*DW-1:0] in_diff,
  input  logic [N_NODES-1:0]    in_mask,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DW-1:0]         out_corr,
  output logic                  out_fail
);

  localparam int M         = N_NODES + 1;
  localparam int CW        = $clog2(M + 1);
  localparam int SW        = DW + CW;
  localparam int KW        = DW + 1;
  localparam int IW        = $clog2(M);
  localparam int SCW       = $clog2(SW + M + 2);
  localparam int MIN_VALID = 3 * K_FAULTS + 1;

  ftac_state_e state_q;
  logic [SCW-1:0] step_q;
  logic [CW-1:0]  nvalid_q;
  logic [CW-1:0]  cnt_in;
  logic           fail_q;
  logic           accept;

  logic [M-1:0][KW-1:0] load_keys;
  logic [M-1:0][KW-1:0] keys;
  logic [IW-1:0]        idx;
  logic                 sum_take;
  logic signed [SW-1:0] sum;
  logic [SW-1:0]        dvd_mag;
  logic [CW-1:0]        dvs;
  logic [SW-1:0]        quo;
  logic [SW-1:0]        quo_signed;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  always_comb begin
    cnt_in = CW'(1);
    for (int i = 0; i < N_NODES; i++) cnt_in = cnt_in + CW'(in_mask[i]);
  end

  // Key = {invalid, value with inverted sign}: unsigned order puts valid
  // readings first, in ascending signed order.
  for (genvar i = 0; i < N_NODES; i++) begin : g_key
    assign load_keys[i] = {~in_mask[i], ~in_diff[i*DW + DW - 1], in_diff[i*DW +: DW-1]};
  end
  assign load_keys[M-1] = {1'b0, 1'b1, {(DW-1){1'b0}}};

  ftac_sort_net #(.M(M), .KW(KW)) u_sort (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .step_i (state_q == ST_SORT),
    .odd_i  (step_q[0]),
    .keys_i (load_keys),
    .keys_o (keys)
  );

  assign idx      = step_q[IW-1:0];
  assign sum_take = (state_q == ST_SUM) && (int'(step_q) >= K_FAULTS)
                    && (int'(step_q) + K_FAULTS < int'(nvalid_q));

  ftac_trim_sum #(.DW(DW), .SW(SW)) u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .take_i  (sum_take),
    .key_i   (keys[idx]),
    .sum_o   (sum)
  );

  assign dvd_mag = sum[SW-1] ? SW'(-sum) : SW'(sum);
  assign dvs     = fail_q ? CW'(1) : CW'(nvalid_q - CW'(2 * K_FAULTS));

  ftac_divider #(.SW(SW), .CW(CW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i ((state_q == ST_DIV) && (step_q == '0)),
    .step_i ((state_q == ST_DIV) && (step_q != '0)),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs),
    .quo_o  (quo)
  );

  assign quo_signed = sum[SW-1] ? SW'(-quo) : quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      nvalid_q  <= '0;
      fail_q    <= 1'b0;
      out_valid <= 1'b0;
      out_corr  <= '0;
      out_fail  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          nvalid_q <= cnt_in;
          fail_q   <= int'(cnt_in) < MIN_VALID;
          step_q   <= '0;
          state_q  <= ST_SORT;
        end
        ST_SORT: if (int'(step_q) == M - 1) begin
          step_q  <= '0;
          state_q <= ST_SUM;
        end else step_q <= step_q + 1'b1;
        ST_SUM: if (int'(step_q) == M - 1) begin
          step_q  <= '0;
          state_q <= ST_DIV;
        end else step_q <= step_q + 1'b1;
        ST_DIV: if (int'(step_q) == SW) begin
          step_q  <= '0;
          state_q <= ST_FIN;
        end else step_q <= step_q + 1'b1;
        ST_FIN: begin
          out_valid <= 1'b1;
          out_fail  <= fail_q;
          out_corr  <= fail_q ? '0 : quo_signed[DW-1:0];
          state_q   <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) begin
          out_valid <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: at the start of the summing pass, the sorter output is ordered
  for (genvar i = 0; i < M - 1; i++) begin : g_ord_chk
    p_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SUM) && (step_q == '0)) |-> (keys[i] <= keys[i+1]));
  end

  // R1: an accepted vector closes the input until the result is taken
  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R8: a held result does not move under back-pressure
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_corr) && $stable(out_fail)));

  // R6: a failing round reports a zero correction
  p_fail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fail) |-> (out_corr == '0));

  // R1: input side and output side are never open together
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

endmodule

// File: tb/ftac_corrector_tb.sv
module ftac_corrector_tb;

  localparam int NN  = 6;
  localparam int DW  = 16;
  localparam int KF  = 1;
  localparam int LAT = 2 * (NN + 1) + (DW + $clog2(NN + 2)) + 2;
  localparam int VW  = NN + NN * DW + DW + 1;
  localparam int NV  = 9;

  // {mask, d5..d0, expected correction, expected fail}
  localparam logic [VW-1:0] VEC [NV] = '{
    {6'b111111, 16'(60), 16'(50), 16'(40), 16'(30), 16'(20), 16'(10), 16'(30), 1'b0},
    {6'b111111, 16'(3), 16'(-4), 16'(2), 16'(1000), 16'(-3), 16'(5), 16'(1), 1'b0},
    {6'b111111, 16'(-4), 16'(-6), 16'(-100), 16'(-9), 16'(-8), 16'(-7), 16'(-6), 1'b0},
    {6'b000111, 16'(5000), 16'(5000), 16'(5000), 16'(9), 16'(-12), 16'(30), 16'(4), 1'b0},
    {6'b000011, 16'(900), 16'(900), 16'(900), 16'(900), 16'(8), 16'(7), 16'(0), 1'b1},
    {6'b000000, 16'(1), 16'(2), 16'(3), 16'(4), 16'(5), 16'(6), 16'(0), 1'b1},
    {6'b111111, 16'(32767), 16'(32767), 16'(32767), 16'(32767), 16'(32767), 16'(32767), 16'(32767), 1'b0},
    {6'b111111, 16'(-32768), 16'(-32768), 16'(-32768), 16'(-32768), 16'(-32768), 16'(-32768), 16'(-32768), 1'b0},
    {6'b101010, 16'(100), 16'(7), 16'(-21), 16'(7), 16'(-20), 16'(7), 16'(-10), 1'b0}
  };
  localparam string VTAG [NV] = '{"R4", "R4", "R5", "R2", "R6", "R6", "R10", "R10", "R2"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NN*DW-1:0] in_diff = '0;
  logic [NN-1:0] in_mask = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_corr;
  logic out_fail;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ftac_corrector #(.N_NODES(NN), .DW(DW), .K_FAULTS(KF)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_diff(in_diff), .in_mask(in_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_corr(out_corr), .out_fail(out_fail)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Offer a vector at a negedge; returns the cycle stamp of the accepting edge.
  task automatic offer(input logic [NN-1:0] m, input logic [NN*DW-1:0] d, output int t0);
    in_mask  = m;
    in_diff  = d;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_result(input string tag, input int t0);
    int guard = 0;
    while (!out_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    // R7: fixed latency from accept to result
    chk({tag, "/R7"}, cyc - t0, LAT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", int'(out_valid), 0);
    chk("R9", int'(in_ready), 1);
    chk("R9", int'(out_corr), 0);
    chk("R9", int'(out_fail), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      offer(e[VW-1 -: NN], e[DW+1 +: NN*DW], t0);
      wait_result(VTAG[v], t0);
      chk({VTAG[v], "/R5"}, int'($signed(out_corr)), int'($signed(e[DW:1])));
      chk({VTAG[v], "/R6"}, int'(out_fail), int'(e[0]));
      @(negedge clk);
    end

    // R1 / R8: back-pressure with interfering input while busy
    out_ready = 1'b0;
    offer(6'b111111, {16'(60), 16'(50), 16'(40), 16'(30), 16'(20), 16'(10)}, t0);
    in_valid = 1'b1;
    in_diff  = {NN{16'(1000)}};
    in_mask  = '1;
    @(negedge clk);
    chk("R1", int'(in_ready), 0);
    repeat (5) @(negedge clk);
    chk("R1", int'(in_ready), 0);
    begin
      int guard = 0;
      while (!out_valid && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    in_valid = 1'b0;
    chk("R7", cyc - t0, LAT);
    chk("R1", int'($signed(out_corr)), 30);
    repeat (5) @(negedge clk);
    chk("R8", int'(out_valid), 1);
    chk("R8", int'($signed(out_corr)), 30);
    chk("R8", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8", int'(out_valid), 0);
    chk("R8", int'(in_ready), 1);

    // R3: reverse-ordered input is ordered before trimming
    offer(6'b111111, {16'(-5), 16'(-4), 16'(-3), 16'(-2), 16'(-1), 16'(25)}, t0);
    wait_result("R3", t0);
    chk("R3", int'($signed(out_corr)), -2);
    @(negedge clk);

    finish_run();
  end

endmodule